// File: doc/BRIEF.md
# Sequential binary-to-BCD converter

This block turns an unsigned binary number into packed decimal digits. It uses the shift-and-add-3 method and handles one input bit per clock. A single working register holds the decimal columns above the binary operand. On every step, each decimal column first gets its add-3 correction, and then the whole register shifts left by one place. The binary MSB enters the units column. After as many steps as there are input bits, the decimal columns hold the answer.

A requester presents a value and pulses `start_i` while the block is idle. The block captures the value on that edge and raises `busy_o` while it works. When the result is ready, it shows the result on `bcd_o` together with a one-cycle `done_o`.

The input width and digit count are parameters. The defaults are 8 bits and 3 digits, which give a 10-bit result. A 16-bit, 5-digit build gives a 19-bit result. The top digit is trimmed to the bits it can ever need.

Top module: `bin2bcd_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy_o` and `done_o` are 0 and `bcd_o` is all zero.
- R2: A `start_i` high at a clock edge while `busy_o` is low captures `bin_i` on that edge, and `busy_o` is high in the following cycle. Later changes on `bin_i` do not affect that conversion.
- R3: With BIN_W input bits, `done_o` is high in exactly the cycle that follows the BIN_W-th edge after the accepting edge. It is low in every earlier cycle of the conversion and low again in the next cycle. `busy_o` is low in the cycle where `done_o` is high.
- R4: The result is the decimal value of the captured input. Units are at `bcd_o[3:0]`, tens at `bcd_o[7:4]`, and hundreds above them. With the 8-bit default, `bcd_o` is 10 bits and the hundreds digit is 2 bits.
- R5: A `start_i` pulse while `busy_o` is high is ignored. The running conversion completes on its original schedule with its original result.
- R6: `bcd_o` keeps the previous result until the cycle in which `done_o` of the next conversion is high.
- R7: With BIN_W=16 and DIGITS=5, `bcd_o` is 19 bits. It holds five digits, the top one 3 bits wide, and covers inputs up to 65535.
- R8: All decimal columns start from zero for each conversion. A result never depends on the previous conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, taken only while idle |
| bin_i | input | BIN_W | Unsigned binary operand |
| bcd_o | output | OUT_W | Packed decimal result, units in the lowest nibble |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse marking a new result |

## Verification
The hardest cases to reach from the ports are the ones where timing overlaps. One is a second start request that arrives in the middle of a conversion. Another is the input bus changing after capture, while the previous result must stay on the outputs. The stimulus forces both cases with directed mid-conversion pulses and input changes on chosen cycles. Every 8-bit value is also converted in turn, so that every column passes through its correction threshold. The 16-bit build is driven with its extremes, with values near decade boundaries, and with seeded random operands.

// File: rtl/bcd_conv_pkg.sv
package bcd_conv_pkg;

  // Smallest bit count that can hold the most significant decimal digit
  // of the largest unsigned value of bin_w bits.
  function automatic int top_digit_bits(input int bin_w, input int digits);
    longint maxv;
    longint scale;
    longint top;
    int     bits;
    maxv  = (longint'(1) << bin_w) - 1;
    scale = 1;
    for (int i = 0; i < digits - 1; i++) scale = scale * 10;
    top  = maxv / scale;
    bits = 40;
    for (int k = 40; k >= 1; k--) begin
      if ((longint'(1) << k) > top) bits = k;
    end
    return bits;
  endfunction

endpackage

// File: rtl/bcd_add3_col.sv
module bcd_add3_col (
  input  logic [3:0] dig_i,
  output logic [3:0] dig_o
);
  // Columns at 5 or above get +3 so the following doubling carries correctly.
  assign dig_o = (dig_i > 4'd4) ? dig_i + 4'd3 : dig_i;
endmodule

// File: rtl/bcd_shift_path.sv
module bcd_shift_path #(
  parameter int BIN_W  = 8,
  parameter int DIGITS = 3
) (
  input  logic [4*DIGITS+BIN_W-1:0] scr_i,
  output logic [4*DIGITS+BIN_W-1:0] scr_o,
  output logic                      carry_o
);
  localparam int BCD_W = 4 * DIGITS;
  localparam int SCR_W = BCD_W + BIN_W;

  logic [BCD_W-1:0] fixed_bcd;

  for (genvar g = 0; g < DIGITS; g++) begin : g_col
    bcd_add3_col u_col (
      .dig_i (scr_i[BIN_W + 4*g +: 4]),
      .dig_o (fixed_bcd[4*g +: 4])
    );
  end

  logic [SCR_W-1:0] fixed_all;
  assign fixed_all = {fixed_bcd, scr_i[BIN_W-1:0]};
  assign scr_o     = {fixed_all[SCR_W-2:0], 1'b0};
  assign carry_o   = fixed_all[SCR_W-1];
endmodule

// File: rtl/bcd_seq_ctrl.sv
module bcd_seq_ctrl #(
  parameter int BIN_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic last_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(BIN_W + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BIN_W - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             done_q;

  assign load_o = start_i && !busy_q;
  assign step_o = busy_q;
  assign last_o = busy_q && (cnt_q == LAST_CNT);
  assign busy_o = busy_q;
  assign done_o = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= last_o;
      if (load_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (last_o) begin
          busy_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cnt_q <= LAST_CNT));                                   // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);                                               // R3
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q);                                               // R3
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start_i && !last_o) |=> (busy_q && cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R5
endmodule

// File: rtl/bin2bcd_seq.sv
module bin2bcd_seq
  import bcd_conv_pkg::*;
#(
  parameter int BIN_W  = 8,
  parameter int DIGITS = 3,
  localparam int OUT_W = top_digit_bits(BIN_W, DIGITS) + 4 * (DIGITS - 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [BIN_W-1:0] bin_i,
  output logic [OUT_W-1:0] bcd_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int BCD_W = 4 * DIGITS;
  localparam int SCR_W = BCD_W + BIN_W;

  logic             load, step, last;
  logic [SCR_W-1:0] scr_q;
  logic [SCR_W-1:0] scr_nxt;
  logic             carry;
  logic [OUT_W-1:0] bcd_q;

  bcd_seq_ctrl #(.BIN_W(BIN_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .load_o  (load),
    .step_o  (step),
    .last_o  (last),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  bcd_shift_path #(.BIN_W(BIN_W), .DIGITS(DIGITS)) u_path (
    .scr_i   (scr_q),
    .scr_o   (scr_nxt),
    .carry_o (carry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      scr_q <= '0;
      bcd_q <= '0;
    end else begin
      if (load) begin
        scr_q <= {{BCD_W{1'b0}}, bin_i};
      end else if (step) begin
        scr_q <= scr_nxt;
      end
      if (last) bcd_q <= scr_nxt[BIN_W +: OUT_W];
    end
  end

  assign bcd_o = bcd_q;

  for (genvar g = 0; g < DIGITS; g++) begin : g_chk
    AST_DIGIT_DECIMAL: assert property (@(posedge clk) disable iff (rst)
      step |-> (scr_q[BIN_W + 4*g +: 4] < 4'd10));                     // R4
  end

  if (OUT_W < BCD_W) begin : g_trim
    AST_TOP_DIGIT_FITS: assert property (@(posedge clk) disable iff (rst)
      last |-> (scr_nxt[SCR_W-1:BIN_W+OUT_W] == '0));                  // R7
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    step |-> !carry);                                                  // R4
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(bcd_q));                                       // R6
  AST_CLEAR_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> (scr_q[SCR_W-1:BIN_W] == '0));                            // R8
endmodule

// File: tb/tb_bin2bcd_seq.sv
`timescale 1ns/1ps
module tb_bin2bcd_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        st8 = 1'b0;
  logic [7:0]  in8 = '0;
  logic [9:0]  bcd8;
  logic        busy8, done8;

  logic        st16 = 1'b0;
  logic [15:0] in16 = '0;
  logic [18:0] bcd16;
  logic        busy16, done16;

  int checks = 0;
  int errors = 0;

  bin2bcd_seq dut (
    .clk(clk), .rst(rst), .start_i(st8), .bin_i(in8),
    .bcd_o(bcd8), .busy_o(busy8), .done_o(done8));

  bin2bcd_seq #(.BIN_W(16), .DIGITS(5)) dut16 (
    .clk(clk), .rst(rst), .start_i(st16), .bin_i(in16),
    .bcd_o(bcd16), .busy_o(busy16), .done_o(done16));

  function automatic logic [31:0] ref_pack(input int unsigned v, input int digits);
    logic [31:0] r;
    int unsigned x;
    r = '0;
    x = v;
    for (int i = 0; i < digits; i++) begin
      r[4*i +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run8(input logic [7:0] v, input bit inject, input string tag);
    logic [31:0] e;
    logic [9:0]  prev;
    e    = ref_pack(v, 3);
    prev = bcd8;
    @(negedge clk);
    in8 = v;
    st8 = 1'b1;
    @(negedge clk);
    st8 = 1'b0;
    chk(busy8 == 1'b1, "R2 busy after start", busy8, 1);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (k == 1) in8 = v ^ 8'h5A;
      if (inject && k == 3) begin
        st8 = 1'b1;
        in8 = ~v;
      end else begin
        st8 = 1'b0;
      end
      if (k < 8) begin
        chk(done8 == 1'b0, "R3 done early", done8, 0);
        if (k == 4) chk(bcd8 == prev, "R6 hold previous", bcd8, prev);
      end else begin
        chk(done8 == 1'b1, "R3 done timing", done8, 1);
        chk(busy8 == 1'b0, "R3 busy low at done", busy8, 0);
        chk(bcd8 == e[9:0], tag, bcd8, e[9:0]);
      end
    end
    @(negedge clk);
    chk(done8 == 1'b0, "R3 done single cycle", done8, 0);
  endtask

  task automatic run16(input logic [15:0] v);
    logic [31:0] e;
    e = ref_pack(v, 5);
    @(negedge clk);
    in16 = v;
    st16 = 1'b1;
    @(negedge clk);
    st16 = 1'b0;
    in16 = ~v;
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      if (k == 16) begin
        chk(done16 == 1'b1, "R3 done timing 16", done16, 1);
        chk(bcd16 == e[18:0], "R7 result 16", bcd16, e[18:0]);
      end
    end
    @(negedge clk);
    chk(done16 == 1'b0, "R3 done single cycle 16", done16, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    chk(busy8 == 1'b0 && done8 == 1'b0, "R1 flags in reset", {busy8, done8}, 0);
    chk(bcd8 == '0, "R1 result in reset", bcd8, 0);
    @(negedge clk);
    rst = 1'b0;
    chk(busy8 == 1'b0 && done8 == 1'b0 && bcd8 == '0, "R1 after reset", bcd8, 0);
    chk(busy16 == 1'b0 && bcd16 == '0, "R1 after reset 16", bcd16, 0);

    run8(8'd0,   1'b0, "R4 zero");
    run8(8'd255, 1'b0, "R4 max");
    for (int v = 0; v < 256; v++) run8(8'(v), 1'b0, "R4 sweep");
    run8(8'd255, 1'b0, "R8 before clear");
    run8(8'd0,   1'b0, "R8 cleared columns");
    run8(8'd200, 1'b1, "R5 start ignored");
    run8(8'd9,   1'b1, "R5 start ignored small");

    run16(16'd0);
    run16(16'd65535);
    run16(16'd9999);
    run16(16'd10000);
    run16(16'd59999);
    for (int i = 0; i < 150; i++) run16(16'($urandom));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule